// File: doc/BRIEF.md
# JTAG Test Access Port with Command Register

This block is an IEEE 1149.1 test access port for a chip's debug and test path. A standard sixteen-state controller advances on each rising edge of the test clock under the mode-select input. It loads a five-bit instruction register, and the decoded instruction chooses which data register is placed between the serial input and the serial output.

The data registers are a single-bit bypass stage, a 32-bit identification word and an 8-bit command register. The boundary scan chain sits outside the block. The block reaches it through a select signal, capture, shift and update enables, and a serial return input. Each time a command scan is updated, the command register hands its byte to the core on a parallel bus, together with a one-cycle strobe.

The serial output changes only on falling test-clock edges. It is enabled only while a shift state is active.

Top module: `jtag_tap_cmd`

## Requirements
- R1: An active-low asynchronous reset puts the controller in Test-Logic-Reset. Five consecutive cycles with TMS high also reach Test-Logic-Reset from any state. In Test-Logic-Reset the instruction register is loaded with IDCODE (5'h01).
- R2: The controller follows the standard 16-state transition graph on rising TCK edges, including the Pause and Exit2 loops.
- R3: The instruction register is 5 bits and shifts LSB first. Capture-IR loads 5'b00001 into the shift stage, so the scan-out order is 1,0,0,0,0. The new instruction takes effect at Update-IR.
- R4: The bypass path is selected by 5'h1F, by 5'h00, by 5'h04 and by every opcode not named in R5, R6 or R8. Bypass is one bit that captures 0, so scan data comes out delayed by one cycle after a leading 0.
- R5: Opcode 5'h01 selects a 32-bit ID word, shifted out LSB first. Bit 0 is 1, bits 11:1 hold the manufacturer code (default 11'h029), bits 27:12 hold the part number and bits 31:28 hold the revision.
- R6: Opcode 5'h07 selects the 8-bit command shift register, shifted LSB first. Capture-DR loads the byte currently presented on cmd_o.
- R7: At the rising edge that leaves Update-DR under opcode 5'h07, cmd_o takes the shifted byte and cmd_stb_o goes high for exactly one cycle. Under any other instruction, cmd_o does not change and no strobe is issued.
- R8: Opcodes 5'h02 and 5'h06 assert bsr_sel_o. TDO then comes from bsr_so_i, and the capture, shift and update enables follow Capture-DR, Shift-DR and Update-DR.
- R9: highz_o is high exactly while opcode 5'h00 is current. extest_o is high exactly while opcode 5'h06 is current.
- R10: TDO and tdo_oe_o are updated on falling TCK edges. tdo_oe_o is high only in Shift-IR and Shift-DR, and TDO is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck_i | input | 1 | Test clock |
| rst_ni | input | 1 | Active-low asynchronous test reset |
| tms_i | input | 1 | Mode select |
| tdi_i | input | 1 | Serial data in |
| tdo_o | output | 1 | Serial data out, changes on falling TCK |
| tdo_oe_o | output | 1 | Output enable for TDO, high in shift states |
| bsr_so_i | input | 1 | Serial return from the boundary chain |
| bsr_sel_o | output | 1 | Boundary chain selected |
| bsr_capture_o | output | 1 | Boundary chain capture enable |
| bsr_shift_o | output | 1 | Boundary chain shift enable |
| bsr_update_o | output | 1 | Boundary chain update enable |
| highz_o | output | 1 | Force all pins to input |
| extest_o | output | 1 | Boundary chain drives pins |
| cmd_o | output | 8 | Last updated command byte |
| cmd_stb_o | output | 1 | One-cycle strobe for a new command byte |

## Verification
The assertions check the following on every cycle:
- Five TMS-high cycles always land in Test-Logic-Reset, and the instruction register holds IDCODE after that state.
- The command strobe never lasts two cycles, and the command byte never changes without it.
- The output enable matches the shift states, and the boundary select follows only the two boundary opcodes.

Only the bench scenarios can show the serial content:
- the exact ID word and its bit order;
- the captured instruction pattern;
- the one-cycle delay through bypass;
- the command readback at Capture-DR;
- the mapping of unlisted opcodes to bypass;
- the timing of TDO on the falling edge.

// File: rtl/jtag_tap_pkg.sv
package jtag_tap_pkg;
  localparam int IR_W = 5;

  typedef enum logic [3:0] {
    TS_RESET, TS_IDLE,
    TS_SEL_DR, TS_CAP_DR, TS_SH_DR, TS_EX1_DR, TS_PAUSE_DR, TS_EX2_DR, TS_UPD_DR,
    TS_SEL_IR, TS_CAP_IR, TS_SH_IR, TS_EX1_IR, TS_PAUSE_IR, TS_EX2_IR, TS_UPD_IR
  } tap_state_e;

  typedef enum logic [1:0] {PATH_BYP, PATH_ID, PATH_CMD, PATH_BSR} dr_path_e;

  localparam logic [IR_W-1:0] OP_HIGHZ  = 5'h00;
  localparam logic [IR_W-1:0] OP_IDCODE = 5'h01;
  localparam logic [IR_W-1:0] OP_SAMPLE = 5'h02;
  localparam logic [IR_W-1:0] OP_SWTAP  = 5'h04;
  localparam logic [IR_W-1:0] OP_EXTEST = 5'h06;
  localparam logic [IR_W-1:0] OP_CMD    = 5'h07;
  localparam logic [IR_W-1:0] OP_BYPASS = 5'h1F;
endpackage

// File: rtl/tap_fsm.sv
module tap_fsm
  import jtag_tap_pkg::*;
(
  input  logic       tck_i,
  input  logic       rst_ni,
  input  logic       tms_i,
  output tap_state_e state_o
);
  tap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      TS_RESET:    state_d = tms_i ? TS_RESET   : TS_IDLE;
      TS_IDLE:     state_d = tms_i ? TS_SEL_DR  : TS_IDLE;
      TS_SEL_DR:   state_d = tms_i ? TS_SEL_IR  : TS_CAP_DR;
      TS_CAP_DR:   state_d = tms_i ? TS_EX1_DR  : TS_SH_DR;
      TS_SH_DR:    state_d = tms_i ? TS_EX1_DR  : TS_SH_DR;
      TS_EX1_DR:   state_d = tms_i ? TS_UPD_DR  : TS_PAUSE_DR;
      TS_PAUSE_DR: state_d = tms_i ? TS_EX2_DR  : TS_PAUSE_DR;
      TS_EX2_DR:   state_d = tms_i ? TS_UPD_DR  : TS_SH_DR;
      TS_UPD_DR:   state_d = tms_i ? TS_SEL_DR  : TS_IDLE;
      TS_SEL_IR:   state_d = tms_i ? TS_RESET   : TS_CAP_IR;
      TS_CAP_IR:   state_d = tms_i ? TS_EX1_IR  : TS_SH_IR;
      TS_SH_IR:    state_d = tms_i ? TS_EX1_IR  : TS_SH_IR;
      TS_EX1_IR:   state_d = tms_i ? TS_UPD_IR  : TS_PAUSE_IR;
      TS_PAUSE_IR: state_d = tms_i ? TS_EX2_IR  : TS_PAUSE_IR;
      TS_EX2_IR:   state_d = tms_i ? TS_UPD_IR  : TS_SH_IR;
      TS_UPD_IR:   state_d = tms_i ? TS_SEL_DR  : TS_IDLE;
      default:     state_d = TS_RESET;
    endcase
  end

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= TS_RESET;
    else         state_q <= state_d;
  end

  assign state_o = state_q;
endmodule

// File: rtl/tap_ir.sv
module tap_ir
  import jtag_tap_pkg::*;
#(
  parameter int                W        = IR_W,
  parameter logic [W-1:0]      CAP_PAT  = 1,
  parameter logic [W-1:0]      RST_OP   = 1
) (
  input  logic         tck_i,
  input  logic         rst_ni,
  input  logic         tdi_i,
  input  tap_state_e   state_i,
  output logic [W-1:0] ir_o,
  output logic         so_o
);
  logic [W-1:0] sh_q, ir_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      ir_q <= RST_OP;
    end else begin
      unique case (state_i)
        TS_RESET:  ir_q <= RST_OP;
        TS_CAP_IR: sh_q <= CAP_PAT;
        TS_SH_IR:  sh_q <= {tdi_i, sh_q[W-1:1]};
        TS_UPD_IR: ir_q <= sh_q;
        default: ;
      endcase
    end
  end

  assign ir_o = ir_q;
  assign so_o = sh_q[0];
endmodule

// File: rtl/tap_dr.sv
module tap_dr
  import jtag_tap_pkg::*;
#(
  parameter int          CMD_W    = 8,
  parameter logic [10:0] MFR_ID   = 11'h029,
  parameter logic [15:0] PART_NUM = 16'h4A5C,
  parameter logic [3:0]  REV      = 4'h3
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tdi_i,
  input  tap_state_e       state_i,
  input  dr_path_e         path_i,
  output logic             so_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_stb_o
);
  localparam int          ID_W   = 32;
  localparam logic [31:0] ID_VAL = {REV, PART_NUM, MFR_ID, 1'b1};

  logic             byp_q;
  logic [ID_W-1:0]  id_sh_q;
  logic [CMD_W-1:0] cmd_sh_q, cmd_q;
  logic             stb_q;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byp_q    <= 1'b0;
      id_sh_q  <= '0;
      cmd_sh_q <= '0;
      cmd_q    <= '0;
      stb_q    <= 1'b0;
    end else begin
      stb_q <= 1'b0;
      unique case (state_i)
        TS_CAP_DR: begin
          byp_q <= 1'b0;
          if (path_i == PATH_ID)  id_sh_q  <= ID_VAL;
          if (path_i == PATH_CMD) cmd_sh_q <= cmd_q;  // readback of last command
        end
        TS_SH_DR: begin
          unique case (path_i)
            PATH_BYP: byp_q    <= tdi_i;
            PATH_ID:  id_sh_q  <= {tdi_i, id_sh_q[ID_W-1:1]};
            PATH_CMD: cmd_sh_q <= {tdi_i, cmd_sh_q[CMD_W-1:1]};
            default: ;
          endcase
        end
        TS_UPD_DR: begin
          if (path_i == PATH_CMD) begin
            cmd_q <= cmd_sh_q;
            stb_q <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (path_i)
      PATH_ID:  so_o = id_sh_q[0];
      PATH_CMD: so_o = cmd_sh_q[0];
      PATH_BYP: so_o = byp_q;
      default:  so_o = 1'b0;
    endcase
  end

  assign cmd_o     = cmd_q;
  assign cmd_stb_o = stb_q;
endmodule

// File: rtl/jtag_tap_cmd.sv
module jtag_tap_cmd
  import jtag_tap_pkg::*;
#(
  parameter int          CMD_W    = 8,
  parameter logic [10:0] MFR_ID   = 11'h029,
  parameter logic [15:0] PART_NUM = 16'h4A5C,
  parameter logic [3:0]  REV      = 4'h3
) (
  input  logic             tck_i,
  input  logic             rst_ni,
  input  logic             tms_i,
  input  logic             tdi_i,
  output logic             tdo_o,
  output logic             tdo_oe_o,
  input  logic             bsr_so_i,
  output logic             bsr_sel_o,
  output logic             bsr_capture_o,
  output logic             bsr_shift_o,
  output logic             bsr_update_o,
  output logic             highz_o,
  output logic             extest_o,
  output logic [CMD_W-1:0] cmd_o,
  output logic             cmd_stb_o
);
  tap_state_e       state_q;
  logic [IR_W-1:0]  ir_q;
  logic             ir_so, dr_so, ser;
  dr_path_e         path;
  logic             in_shift;
  logic             tdo_q, oe_q;

  tap_fsm u_fsm (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tms_i  (tms_i),
    .state_o(state_q)
  );

  tap_ir #(
    .W      (IR_W),
    .CAP_PAT(5'b00001),
    .RST_OP (OP_IDCODE)
  ) u_ir (
    .tck_i  (tck_i),
    .rst_ni (rst_ni),
    .tdi_i  (tdi_i),
    .state_i(state_q),
    .ir_o   (ir_q),
    .so_o   (ir_so)
  );

  always_comb begin
    unique case (ir_q)
      OP_IDCODE:             path = PATH_ID;
      OP_CMD:                path = PATH_CMD;
      OP_SAMPLE, OP_EXTEST:  path = PATH_BSR;
      default:               path = PATH_BYP;  // BYPASS, HIGHZ, SWTAP, undefined
    endcase
  end

  tap_dr #(
    .CMD_W   (CMD_W),
    .MFR_ID  (MFR_ID),
    .PART_NUM(PART_NUM),
    .REV     (REV)
  ) u_dr (
    .tck_i    (tck_i),
    .rst_ni   (rst_ni),
    .tdi_i    (tdi_i),
    .state_i  (state_q),
    .path_i   (path),
    .so_o     (dr_so),
    .cmd_o    (cmd_o),
    .cmd_stb_o(cmd_stb_o)
  );

  assign bsr_sel_o     = (path == PATH_BSR);
  assign bsr_capture_o = bsr_sel_o && (state_q == TS_CAP_DR);
  assign bsr_shift_o   = bsr_sel_o && (state_q == TS_SH_DR);
  assign bsr_update_o  = bsr_sel_o && (state_q == TS_UPD_DR);
  assign highz_o       = (ir_q == OP_HIGHZ);
  assign extest_o      = (ir_q == OP_EXTEST);

  assign in_shift = (state_q == TS_SH_IR) || (state_q == TS_SH_DR);
  assign ser      = (state_q == TS_SH_IR) ? ir_so : (bsr_sel_o ? bsr_so_i : dr_so);

  always_ff @(negedge tck_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      tdo_q <= in_shift ? ser : 1'b0;
      oe_q  <= in_shift;
    end
  end

  assign tdo_o    = tdo_q;
  assign tdo_oe_o = oe_q;
endmodule

// File: rtl/jtag_tap_cmd_chk.sv
module jtag_tap_cmd_chk
  import jtag_tap_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input logic             tck_i,
  input logic             rst_ni,
  input logic             tms_i,
  input logic [3:0]       state,
  input logic [IR_W-1:0]  ir,
  input logic             tdo_oe_o,
  input logic             bsr_sel_o,
  input logic             highz_o,
  input logic [CMD_W-1:0] cmd_o,
  input logic             cmd_stb_o
);
  logic [2:0] ones_cnt;

  always_ff @(posedge tck_i or negedge rst_ni) begin
    if (!rst_ni)            ones_cnt <= '0;
    else if (!tms_i)        ones_cnt <= '0;
    else if (ones_cnt < 5)  ones_cnt <= ones_cnt + 3'd1;
  end

  assert_five_tms_reset_R1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (ones_cnt >= 3'd5) |-> (state == TS_RESET));

  assert_reset_loads_idcode_R1: assert property (@(posedge tck_i) disable iff (!rst_ni)
    (state == TS_RESET) |=> (ir == OP_IDCODE));

  assert_strobe_single_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    cmd_stb_o |=> !cmd_stb_o);

  assert_cmd_change_strobed_R7: assert property (@(posedge tck_i) disable iff (!rst_ni)
    !$stable(cmd_o) |-> cmd_stb_o);

  assert_oe_shift_only_R10: assert property (@(posedge tck_i) disable iff (!rst_ni)
    tdo_oe_o == ((state == TS_SH_DR) || (state == TS_SH_IR)));

  assert_bsr_sel_opcodes_R8: assert property (@(posedge tck_i) disable iff (!rst_ni)
    bsr_sel_o |-> ((ir == OP_SAMPLE) || (ir == OP_EXTEST)));

  assert_highz_not_bsr_R9: assert property (@(posedge tck_i) disable iff (!rst_ni)
    highz_o |-> !bsr_sel_o);
endmodule

bind jtag_tap_cmd jtag_tap_cmd_chk #(.CMD_W(CMD_W)) u_chk (
  .tck_i    (tck_i),
  .rst_ni   (rst_ni),
  .tms_i    (tms_i),
  .state    (state_q),
  .ir       (ir_q),
  .tdo_oe_o (tdo_oe_o),
  .bsr_sel_o(bsr_sel_o),
  .highz_o  (highz_o),
  .cmd_o    (cmd_o),
  .cmd_stb_o(cmd_stb_o)
);

// File: tb/jtag_tap_cmd_test.sv
module jtag_tap_cmd_test;
  localparam logic [10:0] T_MFR  = 11'h029;
  localparam logic [15:0] T_PART = 16'h4A5C;
  localparam logic [3:0]  T_REV  = 4'h3;
  localparam logic [31:0] EXP_ID = {T_REV, T_PART, T_MFR, 1'b1};

  logic       tck_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       tms_i = 1'b1;
  logic       tdi_i = 1'b0;
  logic       tdo_o, tdo_oe_o, bsr_so_i;
  logic       bsr_sel_o, bsr_capture_o, bsr_shift_o, bsr_update_o;
  logic       highz_o, extest_o, cmd_stb_o;
  logic [7:0] cmd_o;

  int n_chk = 0;
  int n_bad = 0;
  logic s_tdo, s_oe;
  logic [3:0] chain_q;

  always #10 tck_i = ~tck_i;

  // Small boundary chain model driven from the select-and-return port
  always_ff @(posedge tck_i) begin
    if (bsr_capture_o)    chain_q <= 4'b1011;
    else if (bsr_shift_o) chain_q <= {tdi_i, chain_q[3:1]};
  end
  assign bsr_so_i = chain_q[0];

  jtag_tap_cmd #(.CMD_W(8), .MFR_ID(T_MFR), .PART_NUM(T_PART), .REV(T_REV)) uut (
    .tck_i, .rst_ni, .tms_i, .tdi_i, .tdo_o, .tdo_oe_o, .bsr_so_i,
    .bsr_sel_o, .bsr_capture_o, .bsr_shift_o, .bsr_update_o,
    .highz_o, .extest_o, .cmd_o, .cmd_stb_o
  );

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic tick(input logic tms, input logic tdi);
    @(negedge tck_i);
    #2;
    tms_i = tms;
    tdi_i = tdi;
    s_tdo = tdo_o;
    s_oe  = tdo_oe_o;
    @(posedge tck_i);
  endtask

  // From Run-Test/Idle, scan n bits, return to Run-Test/Idle
  task automatic scan(input bit is_ir, input logic [31:0] din, input int n,
                      output logic [31:0] dout, output bit oe_ok);
    dout = '0;
    oe_ok = 1'b1;
    tick(1, 0);
    if (is_ir) tick(1, 0);
    tick(0, 0);
    tick(0, 0);
    for (int i = 0; i < n; i++) begin
      tick(i == n - 1, din[i]);
      dout[i] = s_tdo;
      oe_ok &= s_oe;
    end
    tick(1, 0);
    tick(0, 0);
  endtask

  task automatic set_ir(input logic [4:0] op, output logic [31:0] cap);
    bit ok;
    scan(1, {27'd0, op}, 5, cap, ok);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    bit ok;
    #1;
    chk(!tdo_oe_o && !cmd_stb_o && !highz_o && !extest_o && !bsr_sel_o,
        "R1", "reset outputs", {27'd0, tdo_oe_o, cmd_stb_o, highz_o, extest_o, bsr_sel_o}, 0);
    chk(cmd_o == 8'h00, "R7", "cmd after reset", cmd_o, 0);
    tick(0, 0);
    scan(0, 32'h0, 32, d, ok);
    chk(d == EXP_ID, "R5", "IDCODE after reset (R1)", d, EXP_ID);
    chk(ok, "R10", "oe during shift", ok, 1);
    tick(0, 0);
    tick(0, 0);
    chk(!s_oe, "R10", "oe in idle", s_oe, 0);
  endtask

  task automatic t_ir_capture();
    logic [31:0] cap;
    set_ir(5'h1F, cap);
    chk(cap[4:0] == 5'b00001, "R3", "IR capture pattern", cap[4:0], 5'b00001);
  endtask

  task automatic t_bypass();
    logic [31:0] d;
    bit ok;
    scan(0, 32'hB6, 8, d, ok);
    chk(d[7:0] == 8'h6C, "R4", "bypass one-cycle delay", d[7:0], 8'h6C);
    // TDO moves on the falling edge only
    tick(1, 0);
    tick(0, 0);
    tick(0, 0);
    tick(0, 1);
    #2;
    chk(tdo_o == 1'b0, "R10", "TDO held after rising edge", tdo_o, 0);
    @(negedge tck_i);
    #2;
    chk(tdo_o == 1'b1, "R10", "TDO after falling edge", tdo_o, 1);
    tick(1, 0);
    tick(1, 0);
    tick(0, 0);
  endtask

  task automatic t_tms_reset();
    logic [31:0] d;
    bit ok;
    for (int i = 0; i < 5; i++) tick(1, 0);
    tick(0, 0);
    scan(0, 32'h0, 32, d, ok);
    chk(d == EXP_ID, "R1", "IDCODE after five TMS high (R2)", d, EXP_ID);
  endtask

  task automatic t_pause_loop();
    logic [31:0] d;
    // Shift 4 bits, pause, resume, shift rest of ID (R2)
    tick(1, 0);
    tick(0, 0);
    tick(0, 0);
    d = '0;
    for (int i = 0; i < 4; i++) begin
      tick(i == 3, 0);
      d[i] = s_tdo;
    end
    tick(0, 0);
    tick(0, 0);
    tick(1, 0);
    tick(0, 0);
    for (int i = 4; i < 32; i++) begin
      tick(i == 31, 0);
      d[i] = s_tdo;
    end
    tick(1, 0);
    tick(0, 0);
    chk(d == EXP_ID, "R2", "ID across Pause-DR", d, EXP_ID);
  endtask

  task automatic t_other_bypass();
    logic [31:0] cap, d;
    bit ok;
    set_ir(5'h0A, cap);
    scan(0, 32'h5, 4, d, ok);
    chk(d[3:0] == 4'hA, "R4", "undefined opcode bypass", d[3:0], 4'hA);
    set_ir(5'h04, cap);
    scan(0, 32'h3, 4, d, ok);
    chk(d[3:0] == 4'h6, "R4", "switch opcode bypass", d[3:0], 4'h6);
    set_ir(5'h00, cap);
    #1;
    chk(highz_o && !extest_o && !bsr_sel_o, "R9", "highz decode",
        {highz_o, extest_o, bsr_sel_o}, 3'b100);
    scan(0, 32'h1, 3, d, ok);
    chk(d[2:0] == 3'b010, "R4", "highz bypass", d[2:0], 3'b010);
  endtask

  task automatic t_command();
    logic [31:0] cap, d;
    bit ok;
    set_ir(5'h07, cap);
    scan(0, 32'hA5, 8, d, ok);
    chk(d[7:0] == 8'h00, "R6", "cmd capture first", d[7:0], 0);
    #1;
    chk(cmd_stb_o, "R7", "strobe high", cmd_stb_o, 1);
    chk(cmd_o == 8'hA5, "R7", "cmd updated", cmd_o, 8'hA5);
    tick(0, 0);
    #1;
    chk(!cmd_stb_o, "R7", "strobe one cycle", cmd_stb_o, 0);
    scan(0, 32'h3C, 8, d, ok);
    chk(d[7:0] == 8'hA5, "R6", "cmd readback", d[7:0], 8'hA5);
    #1;
    chk(cmd_o == 8'h3C, "R7", "cmd second update", cmd_o, 8'h3C);
    set_ir(5'h1F, cap);
    scan(0, 32'hFF, 8, d, ok);
    #1;
    chk(!cmd_stb_o && cmd_o == 8'h3C, "R7", "no strobe outside command",
        {cmd_stb_o, cmd_o}, {1'b0, 8'h3C});
  endtask

  task automatic t_boundary();
    logic [31:0] cap, d;
    bit ok;
    set_ir(5'h02, cap);
    #1;
    chk(bsr_sel_o && !extest_o && !highz_o, "R8", "sample select",
        {bsr_sel_o, extest_o, highz_o}, 3'b100);
    scan(0, 32'h6, 4, d, ok);
    chk(d[3:0] == 4'b1011, "R8", "boundary return data", d[3:0], 4'b1011);
    chk(chain_q == 4'b0110, "R8", "boundary shift enable", chain_q, 4'b0110);
    set_ir(5'h06, cap);
    #1;
    chk(bsr_sel_o && extest_o && !highz_o, "R9", "extest decode",
        {bsr_sel_o, extest_o, highz_o}, 3'b110);
  endtask

  initial begin
    #(200000 * 20);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual hung expected done");
    summary();
  end

  initial begin
    @(negedge tck_i);
    #3 rst_ni = 1'b1;
    t_reset();
    t_ir_capture();
    t_bypass();
    t_tms_reset();
    t_pause_loop();
    t_other_bypass();
    t_command();
    t_boundary();
    summary();
  end
endmodule